// File: doc/BRIEF.md
# DTR Pin Mode Controller

This block drives the active-low DTR output pin of a serial port. A small write port sets a two-bit mode, two clock-output override bits, a software DTR value and a pair of receive-FIFO thresholds. Depending on the mode, the pin behaves as a plain modem-control line, as a receive flow-control line with hysteresis, or as the enable of an external RS485 line driver of either polarity. The receive-FIFO level, the transmitter status, the serial output line, a 1x transmit clock and an Nx baud clock all come in from neighbouring logic.

When an override bit is set, the pin carries one of the two clocks and the mode function is set aside. The Nx clock wins when both overrides are set. Mode-driven pin values are registered, so the pin does not glitch. The clock outputs are passed through a multiplexer and are not registered.

Top module: `dtr_pin_ctrl`

## Requirements
- R1: After reset the pin `dtrN` is high, the mode is legacy (00), both overrides are clear, the software DTR value is 0, and the flow-control hysteresis state is clear.
- R2: A write to address 0 sets mode = wrData[1:0], 1x-clock override = wrData[2], Nx-clock override = wrData[3] and software DTR = wrData[4]. Address 1 sets the upper threshold and address 2 sets the lower threshold. A write to address 3 changes nothing.
- R3: In mode 00 the pin is the inverse of the software DTR value: `dtrN` is low when software DTR is 1.
- R4: In mode 01 the pin goes high once `rxLevel` is greater than or equal to the upper threshold.
- R5: In mode 01 the pin goes back low only when `rxLevel` is strictly below the lower threshold. While the level is between the thresholds, the pin keeps its previous value.
- R6: In mode 10 the pin is low while the transmitter is not empty and high when it is empty.
- R7: In mode 11 the pin is high while the transmitter is not empty and low when it is empty.
- R8: The transmitter counts as empty only when `txEmpty` is 1 and `serialOut` is at the idle mark level (1).
- R9: With only the 1x override set, the pin follows `txClk1x` combinationally.
- R10: With the Nx override set, the pin follows `baudClkNx`, whether or not the 1x override is also set.
- R11: Every write to address 0 clears the hysteresis state, even when the mode is unchanged. A level between the thresholds then leaves the pin low.
- R12: A change on a mode input appears on the pin at the next clock edge. A register write appears on the pin one edge after the edge that captured it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register address |
| wrData | input | 8 | Register write data |
| rxLevel | input | 8 | Receive FIFO fill level |
| txEmpty | input | 1 | Transmit FIFO and shift register empty |
| serialOut | input | 1 | Current serial output line level |
| txClk1x | input | 1 | 1x transmit clock |
| baudClkNx | input | 1 | Nx baud generator clock |
| dtrN | output | 1 | DTR pin, active low |

## Verification
The bench works the hysteresis band from both sides: it holds the level exactly at the lower threshold (the pin must stay high) and exactly at the upper threshold (the pin must go high). A design that compared with the wrong inequality, or that had no memory, would flip early or chatter inside the band. It drives an empty transmitter with the serial line still low. A design that ignored the line would drop the RS485 enable before the stop bit. It sets both overrides, where a wrong priority shows the 1x clock. It rewrites the same mode while the level sits inside the band, to catch hysteresis state that survives the write. A last sequence samples the pin one edge and two edges after a write, to pin down the latency.

// File: rtl/dtr_pin_pkg.sv
package dtr_pin_pkg;
  localparam int LEVEL_W = 8;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 2;

  typedef enum logic [1:0] {
    MODE_LEGACY  = 2'b00,
    MODE_FLOW    = 2'b01,
    MODE_RS485_L = 2'b10,
    MODE_RS485_H = 2'b11
  } pinMode_e;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_CFG  = 2'd0,
    ADDR_UPPER = 2'd1,
    ADDR_LOWER = 2'd2,
    ADDR_NONE = 2'd3
  } regAddr_e;

  typedef struct packed {
    logic clrHyst;
    logic selFlow;
    logic selRs485;
    logic rs485High;
    logic selClk1x;
    logic selClkNx;
    logic legacyLevel;
  } dtrStrobe_t;
endpackage

// File: rtl/dtr_pin_ctrl_regs.sv
module dtr_pin_ctrl_regs
  import dtr_pin_pkg::*;
#(
  parameter int LW = LEVEL_W,
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic [DW-1:0] wrData,
  output dtrStrobe_t    strobe,
  output logic [LW-1:0] upThr,
  output logic [LW-1:0] lowThr
);
  localparam logic [LW-1:0] UP_RST  = '1;
  localparam logic [LW-1:0] LOW_RST = '0;

  pinMode_e modeReg;
  logic     ovr1x;
  logic     ovrNx;
  logic     swDtr;
  logic     clrPend;
  logic     cfgWr;

  assign cfgWr = wrEn && (wrAddr == ADDR_CFG);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg <= MODE_LEGACY;
      ovr1x   <= 1'b0;
      ovrNx   <= 1'b0;
      swDtr   <= 1'b0;
      upThr   <= UP_RST;
      lowThr  <= LOW_RST;
      clrPend <= 1'b0;
    end else begin
      clrPend <= cfgWr;
      if (wrEn) begin
        unique case (wrAddr)
          ADDR_CFG: begin
            modeReg <= pinMode_e'(wrData[1:0]);
            ovr1x   <= wrData[2];
            ovrNx   <= wrData[3];
            swDtr   <= wrData[4];
          end
          ADDR_UPPER: upThr  <= wrData[LW-1:0];
          ADDR_LOWER: lowThr <= wrData[LW-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    strobe             = '0;
    strobe.clrHyst     = clrPend;
    strobe.selFlow     = (modeReg == MODE_FLOW);
    strobe.selRs485    = modeReg[1];
    strobe.rs485High   = (modeReg == MODE_RS485_H);
    strobe.selClk1x    = ovr1x;
    strobe.selClkNx    = ovrNx;
    strobe.legacyLevel = ~swDtr;
  end

  p_cfg_mode_r2: assert property (@(posedge clk) disable iff (!rstN)
    cfgWr |=> (modeReg == pinMode_e'($past(wrData[1:0]))));
  p_unused_addr_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ADDR_NONE) |=> ($stable(upThr) && $stable(lowThr) && $stable(modeReg)));
  p_clear_follows_write_r11: assert property (@(posedge clk) disable iff (!rstN)
    cfgWr |=> strobe.clrHyst);
endmodule

// File: rtl/dtr_pin_datapath.sv
module dtr_pin_datapath
  import dtr_pin_pkg::*;
#(
  parameter int LW = LEVEL_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  dtrStrobe_t    strobe,
  input  logic [LW-1:0] upThr,
  input  logic [LW-1:0] lowThr,
  input  logic [LW-1:0] rxLevel,
  input  logic          txEmpty,
  input  logic          serialOut,
  input  logic          txClk1x,
  input  logic          baudClkNx,
  output logic          dtrN
);
  logic flowOff;
  logic flowOffNext;
  logic atUpper;
  logic belowLower;
  logic txIdle;
  logic modeLevel;
  logic pinReg;

  assign atUpper    = (rxLevel >= upThr);
  assign belowLower = (rxLevel < lowThr);
  assign txIdle     = txEmpty && serialOut;

  always_comb begin
    if (!strobe.selFlow)      flowOffNext = 1'b0;
    else if (atUpper)         flowOffNext = 1'b1;
    else if (strobe.clrHyst)  flowOffNext = 1'b0;
    else if (belowLower)      flowOffNext = 1'b0;
    else                      flowOffNext = flowOff;
  end

  always_comb begin
    if (strobe.selFlow)       modeLevel = flowOffNext;
    else if (strobe.selRs485) modeLevel = strobe.rs485High ? ~txIdle : txIdle;
    else                      modeLevel = strobe.legacyLevel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flowOff <= 1'b0;
      pinReg  <= 1'b1;
    end else begin
      flowOff <= flowOffNext;
      pinReg  <= modeLevel;
    end
  end

  always_comb begin
    if (strobe.selClkNx)      dtrN = baudClkNx;
    else if (strobe.selClk1x) dtrN = txClk1x;
    else                      dtrN = pinReg;
  end

  p_flow_set_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.selFlow && atUpper) |=> flowOff);
  p_flow_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.selFlow && !strobe.clrHyst && !atUpper && !belowLower) |=> $stable(flowOff));
  p_rs485_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.selRs485 && !strobe.rs485High && !txIdle) |=> !pinReg);
  p_flow_pin_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.selClkNx && !strobe.selClk1x && flowOff) |-> dtrN);
endmodule

// File: rtl/dtr_pin_ctrl.sv
module dtr_pin_ctrl
  import dtr_pin_pkg::*;
#(
  parameter int LW = LEVEL_W,
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic [DW-1:0] wrData,
  input  logic [LW-1:0] rxLevel,
  input  logic          txEmpty,
  input  logic          serialOut,
  input  logic          txClk1x,
  input  logic          baudClkNx,
  output logic          dtrN
);
  dtrStrobe_t    strobe;
  logic [LW-1:0] upThr;
  logic [LW-1:0] lowThr;

  dtr_pin_ctrl_regs #(.LW(LW), .DW(DW), .AW(AW)) regs_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .strobe(strobe), .upThr(upThr), .lowThr(lowThr)
  );

  dtr_pin_datapath #(.LW(LW)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .upThr(upThr), .lowThr(lowThr),
    .rxLevel(rxLevel), .txEmpty(txEmpty), .serialOut(serialOut),
    .txClk1x(txClk1x), .baudClkNx(baudClkNx), .dtrN(dtrN)
  );
endmodule

// File: tb/dtr_pin_ctrl_tb.sv
module dtr_pin_ctrl_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rxLevel = '0;
  logic       txEmpty = 1'b1;
  logic       serialOut = 1'b1;
  logic       txClk1x = 1'b0;
  logic       baudClkNx = 1'b0;
  logic       dtrN;

  int total = 0;
  int bad = 0;
  logic  expQ[$];
  string tagQ[$];
  bit    done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dtr_pin_ctrl dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rxLevel(rxLevel), .txEmpty(txEmpty), .serialOut(serialOut),
    .txClk1x(txClk1x), .baudClkNx(baudClkNx), .dtrN(dtrN)
  );

  task automatic push(input logic val, input string tag);
    expQ.push_back(val);
    tagQ.push_back(tag);
  endtask

  task automatic settle(input logic val, input string tag);
    repeat (2) @(posedge clk);
    #1;
    push(val, tag);
    wait (expQ.size() == 0);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk);
    #1;
    wrEn = 1'b0;
  endtask

  // monitor: compares one expected value per falling edge
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      logic  e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      total++;
      if (dtrN !== e) begin
        bad++;
        $display("FAIL %s: dtrN=%b expected=%b", t, dtrN, e);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    push(1'b1, "R1 pin high in reset");
    wait (expQ.size() == 0);
    rstN = 1'b1;
    settle(1'b1, "R1 pin high after reset");

    // R3 legacy
    wr(0, 8'h10); settle(1'b0, "R3 swDtr=1 drives low");
    wr(0, 8'h00); settle(1'b1, "R3 swDtr=0 drives high");

    // R2 thresholds and dead address
    wr(1, 8'd20);
    wr(2, 8'd10);
    wr(3, 8'hFF); settle(1'b1, "R2 address 3 write ignored");

    // R4 / R5 hysteresis
    wr(0, 8'h01);
    rxLevel = 8'd5;  settle(1'b0, "R4 below upper stays active");
    rxLevel = 8'd20; settle(1'b1, "R4 level equals upper");
    rxLevel = 8'd15; settle(1'b1, "R5 hold inside band");
    rxLevel = 8'd10; settle(1'b1, "R5 level equals lower holds");
    rxLevel = 8'd9;  settle(1'b0, "R5 below lower releases");
    rxLevel = 8'd15; settle(1'b0, "R5 hold low inside band");
    rxLevel = 8'd25; settle(1'b1, "R4 above upper");

    // R11 rewrite same mode clears state
    rxLevel = 8'd15;
    wr(0, 8'h01); settle(1'b0, "R11 rewrite clears hysteresis");

    // R6 / R8 active-low RS485
    wr(0, 8'h02);
    txEmpty = 1'b0; serialOut = 1'b1; settle(1'b0, "R6 busy drives low");
    txEmpty = 1'b1; serialOut = 1'b0; settle(1'b0, "R8 stop bit pending keeps enable");
    serialOut = 1'b1; settle(1'b1, "R6 idle releases high");

    // R7 / R8 active-high RS485
    wr(0, 8'h03);
    txEmpty = 1'b0; settle(1'b1, "R7 busy drives high");
    txEmpty = 1'b1; settle(1'b0, "R7 idle drives low");
    serialOut = 1'b0; settle(1'b1, "R8 line low means not empty");
    serialOut = 1'b1;

    // R9 1x override
    wr(0, 8'h07);
    txClk1x = 1'b1; settle(1'b1, "R9 follows 1x clock high");
    txClk1x = 1'b0; settle(1'b0, "R9 follows 1x clock low");

    // R10 Nx override priority
    txClk1x = 1'b1;
    wr(0, 8'h0F);
    baudClkNx = 1'b0; settle(1'b0, "R10 Nx wins over 1x");
    baudClkNx = 1'b1; settle(1'b1, "R10 follows Nx high");
    wr(0, 8'h0B);
    baudClkNx = 1'b0; settle(1'b0, "R10 Nx alone");

    // R12 latency
    wr(0, 8'h00); settle(1'b1, "R12 legacy idle");
    wr(0, 8'h10);
    push(1'b1, "R12 unchanged one edge after capture");
    wait (expQ.size() == 0);
    @(posedge clk); #1;
    push(1'b0, "R12 changed on following edge");
    wait (expQ.size() == 0);

    @(negedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule